// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block stores received Ethernet frames into buffers that the host has handed over through a circular ring of four-word descriptors in shared memory. A frame arrives as a byte stream. When its first byte appears, the engine reads the descriptor at the current ring slot. If the host has handed that slot over, the engine reads the buffer pointer and the buffer capacity. It then packs the frame bytes two per 16-bit word into the buffer. Afterwards it writes back the stored byte count and the error flags. Its last action is to hand the slot back to the host, and it may then pulse an interrupt.

A slot that the host still holds causes the whole frame to be discarded. The engine reports this with a one-cycle missed pulse and stays on the same slot, so the next frame tries it again. Once the host has set the slot's ownership bit again, the slot can be filled. Medium access, CRC computation and line coding happen upstream; their verdicts arrive as flags on the last byte.

Memory is word addressed with 16-bit data. A read returns its data in the cycle after `mem_rd`. Writes complete in the cycle they are issued.

Top module: `rx_ring_engine`

## Requirements
- R1: After reset, `in_ready`, `irq`, `missed`, `mem_rd` and `mem_wr` are all low, and the first frame uses ring slot 0.
- R2: Slot i lives at `cfg_ring_base + 4*i`. Word +0 holds the buffer word address, word +1 holds the flags (bit 15 = ownership, 1 = engine may fill), word +2 holds the buffer capacity in bytes, and word +3 receives the byte count. The first memory access for a frame is a read of word +1.
- R3: If the ownership bit read is 0, the frame is consumed without any memory write, `missed` pulses for exactly one cycle after its last byte, and the ring slot is not advanced.
- R4: Frame bytes are packed little-endian: byte 2k goes into bits 7:0 and byte 2k+1 into bits 15:8 of buffer word k. An odd final byte is written with bits 15:8 zero.
- R5: Word +3 is written with the number of bytes actually stored in the buffer.
- R6: Bytes beyond the buffer capacity are not written. The stored count equals the capacity, and overflow status bit 2 is set.
- R7: The final status in word +1 is `{own, 12'b0, overflow, framing_error, crc_error}`. Bit 0 and bit 1 are taken from `in_crc_err` and `in_frm_err` with the last byte.
- R8: Write-back order is fixed: first the count to word +3, then word +1 with ownership still 1 and the status, and finally a separate write of word +1 with ownership 0.
- R9: When `cfg_irq_en` is 1, `irq` pulses for one cycle, in the cycle right after the ownership-release write. When it is 0, no pulse occurs.
- R10: The slot index advances by one after each stored frame and wraps to 0 after slot 2^`cfg_ring_log2` − 1 (ring of 1 to 128 slots).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ring_base | input | AW | Word address of slot 0 |
| cfg_ring_log2 | input | 3 | Ring size as log2 of slot count (0..7) |
| cfg_irq_en | input | 1 | Enable completion interrupt |
| in_valid | input | 1 | Frame byte present |
| in_ready | output | 1 | Byte accepted on this edge when high with in_valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_crc_err | input | 1 | CRC verdict, valid with in_last |
| in_frm_err | input | 1 | Framing verdict, valid with in_last |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Read data, one cycle after mem_rd |
| irq | output | 1 | One-cycle completion interrupt |
| missed | output | 1 | One-cycle pulse for a frame dropped on an unowned slot |

## Verification
Directed frames of even length, odd length and length above capacity each exercise a different path. The even frame ends exactly on a word boundary. The odd frame needs the trailing half-word flush. The long frame must stop at the capacity and set the overflow flag, and a word written just past the buffer shows that nothing spills over. A slot still held by the host separates the drop path from the fill path, because memory must stay untouched and the slot index must stay put. Seeded random frames then vary length, capacity, error flags, ownership and interrupt enable, and they run long enough to wrap rings of four slots and of one slot. For every frame, the bench checks the buffer words, the count, the status word, the order of the write-backs and the timing of the interrupt against values it computes itself.

// File: rtl/rx_ring_engine.sv
module rx_ring_engine #(
  parameter int AW   = 16,
  parameter int IDXW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cfg_ring_base,
  input  logic [2:0]    cfg_ring_log2,
  input  logic          cfg_irq_en,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  input  logic          in_crc_err,
  input  logic          in_frm_err,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata,
  output logic          irq,
  output logic          missed
);

  typedef enum logic [3:0] {
    S_IDLE, S_RD_FLG, S_CHK_OWN, S_GET_BUF, S_GET_CAP,
    S_DATA, S_FLUSH, S_WB_CNT, S_WB_STAT, S_WB_REL, S_DROP
  } st_t;

  st_t             st;
  logic [IDXW-1:0] slot;
  logic [AW-1:0]   buf_q;
  logic [15:0]     cap_q;
  logic [15:0]     nst;
  logic [7:0]      lo_q;
  logic            ovf_q, crc_q, frm_q;

  logic [IDXW-1:0] mask, slot_eff, slot_nxt;
  logic [AW-1:0]   desc;
  logic            full, take, odd_after;
  logic [15:0]     stat_word;

  assign mask      = IDXW'((32'd1 << cfg_ring_log2) - 32'd1);
  assign slot_eff  = slot & mask;
  assign slot_nxt  = (slot_eff + 1'b1) & mask;
  assign desc      = cfg_ring_base + AW'({slot_eff, 2'b00});
  assign full      = nst >= cap_q;
  assign take      = in_valid && in_ready;
  assign odd_after = full ? nst[0] : ~nst[0];
  assign stat_word = {1'b1, 12'b0, ovf_q, frm_q, crc_q};

  assign in_ready = (st == S_DATA) || (st == S_DROP);
  assign mem_rd   = (st == S_RD_FLG) || (st == S_GET_BUF) ||
                    ((st == S_CHK_OWN) && mem_rdata[15]);
  assign mem_wr   = ((st == S_DATA) && in_valid && nst[0] && !full) ||
                    (st == S_FLUSH) || (st == S_WB_CNT) ||
                    (st == S_WB_STAT) || (st == S_WB_REL);

  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    case (st)
      S_RD_FLG:  mem_addr = desc + AW'(1);
      S_CHK_OWN: mem_addr = desc;
      S_GET_BUF: mem_addr = desc + AW'(2);
      S_DATA: begin
        mem_addr  = buf_q + AW'(nst >> 1);
        mem_wdata = {in_data, lo_q};
      end
      S_FLUSH: begin
        mem_addr  = buf_q + AW'(nst >> 1);
        mem_wdata = {8'h00, lo_q};
      end
      S_WB_CNT: begin
        mem_addr  = desc + AW'(3);
        mem_wdata = nst;
      end
      S_WB_STAT: begin
        mem_addr  = desc + AW'(1);
        mem_wdata = stat_word;
      end
      S_WB_REL: begin
        mem_addr  = desc + AW'(1);
        mem_wdata = {1'b0, stat_word[14:0]};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      slot   <= '0;
      buf_q  <= '0;
      cap_q  <= '0;
      nst    <= '0;
      lo_q   <= '0;
      ovf_q  <= 1'b0;
      crc_q  <= 1'b0;
      frm_q  <= 1'b0;
      irq    <= 1'b0;
      missed <= 1'b0;
    end else begin
      irq    <= (st == S_WB_REL) && cfg_irq_en;
      missed <= (st == S_DROP) && take && in_last;
      case (st)
        S_IDLE:    if (in_valid) st <= S_RD_FLG;
        S_RD_FLG:  st <= S_CHK_OWN;
        S_CHK_OWN: st <= mem_rdata[15] ? S_GET_BUF : S_DROP;
        S_GET_BUF: begin
          buf_q <= AW'(mem_rdata);
          st    <= S_GET_CAP;
        end
        S_GET_CAP: begin
          cap_q <= mem_rdata;
          nst   <= '0;
          ovf_q <= 1'b0;
          st    <= S_DATA;
        end
        S_DATA: if (take) begin
          if (full) ovf_q <= 1'b1;
          else begin
            if (!nst[0]) lo_q <= in_data;
            nst <= nst + 16'd1;
          end
          if (in_last) begin
            crc_q <= in_crc_err;
            frm_q <= in_frm_err;
            st    <= odd_after ? S_FLUSH : S_WB_CNT;
          end
        end
        S_FLUSH:   st <= S_WB_CNT;
        S_WB_CNT:  st <= S_WB_STAT;
        S_WB_STAT: st <= S_WB_REL;
        S_WB_REL: begin
          slot <= slot_nxt;
          st   <= S_IDLE;
        end
        S_DROP:    if (take && in_last) st <= S_IDLE;
        default:   st <= S_IDLE;
      endcase
    end
  end

  AST_FETCH_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> !in_ready); // R2
  AST_RD_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R2
  AST_DROP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DROP) |-> !mem_wr); // R3
  AST_MISS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    missed |=> !missed); // R3
  AST_BUF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_DATA) && mem_wr) |-> (nst < cap_q)); // R6
  AST_RELEASE_AFTER_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !mem_wdata[15] && (mem_addr == desc + AW'(1))) |->
      $past(mem_wr && mem_wdata[15] && (mem_addr == desc + AW'(1)))); // R8
  AST_IRQ_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(mem_wr && !mem_wdata[15] && (mem_addr == desc + AW'(1)))); // R9
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R9

endmodule

// File: tb/rx_ring_engine_tb.sv
`timescale 1ns/1ps
module rx_ring_engine_tb_top;
  localparam int AW = 16;
  localparam logic [15:0] BASE = 16'h0100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] cfg_ring_base = BASE;
  logic [2:0] cfg_ring_log2 = 3'd2;
  logic cfg_irq_en = 1'b1;
  logic in_valid = 1'b0, in_last = 1'b0, in_crc_err = 1'b0, in_frm_err = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, mem_rd, mem_wr, irq, missed;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;

  always #2 clk = ~clk;

  rx_ring_engine #(.AW(AW), .IDXW(7)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_ring_base(cfg_ring_base),
    .cfg_ring_log2(cfg_ring_log2), .cfg_irq_en(cfg_irq_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .in_crc_err(in_crc_err), .in_frm_err(in_frm_err),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq), .missed(missed));

  logic [15:0] mem [0:4095];
  logic h_we = 1'b0;
  logic [15:0] h_a = '0, h_d = '0;
  int cyc = 0, wr_cnt = 0, irq_cnt = 0, miss_cnt = 0;
  int len_t = -1, stat_t = -1, rel_t = -1, irq_t = -1;
  logic [15:0] stat_seen = '0, start_addr = '0, cur_desc = '0;
  logic prev_rd = 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    prev_rd <= mem_rd;
    if (h_we) mem[h_a[11:0]] <= h_d;
    if (mem_rd) begin
      mem_rdata <= mem[mem_addr[11:0]];
      if (!prev_rd) start_addr <= mem_addr;
    end
    if (mem_wr) begin
      mem[mem_addr[11:0]] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
      if (mem_addr == cur_desc + 16'd3) len_t <= cyc;
      if (mem_addr == cur_desc + 16'd1) begin
        if (mem_wdata[15]) begin stat_t <= cyc; stat_seen <= mem_wdata; end
        else rel_t <= cyc;
      end
    end
    if (irq) begin irq_cnt <= irq_cnt + 1; irq_t <= cyc; end
    if (missed) miss_cnt <= miss_cnt + 1;
  end

  int n_cmp = 0, n_bad = 0;
  int exp_slot = 0;
  logic [7:0] fb [0:255];

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(input int k, input int stored);
    logic [7:0] hi;
    hi = (2*k+1 < stored) ? fb[2*k+1] : 8'h00;
    return {hi, fb[2*k]};
  endfunction

  task automatic hwrite(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); h_we = 1'b1; h_a = a; h_d = d;
    @(negedge clk); h_we = 1'b0;
  endtask

  task automatic send(input int n, input logic ce, input logic fe);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = fb[i]; in_last = (i == n-1);
      in_crc_err = ce; in_frm_err = fe;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; in_crc_err = 1'b0; in_frm_err = 1'b0;
  endtask

  task automatic frame(input int n, input int cap, input logic own,
                       input logic ce, input logic fe, input logic ien);
    logic [15:0] d, bufa;
    int stored, nw, w0, i0, m0, t0, bad, mask, prev;
    logic ovf;
    mask = (1 << cfg_ring_log2) - 1;
    exp_slot = exp_slot & mask;
    prev = exp_slot;
    d = BASE + 16'(exp_slot * 4);
    bufa = 16'h0400 + 16'(exp_slot * 16'h0080);
    stored = (n < cap) ? n : cap;
    ovf = (n > cap);
    nw = (stored + 1) / 2;
    cur_desc = d;
    cfg_irq_en = ien;
    hwrite(d, bufa);
    hwrite(d + 16'd1, {own, 15'h0});
    hwrite(d + 16'd2, 16'(cap));
    hwrite(d + 16'd3, 16'hDEAD);
    hwrite(bufa + 16'(nw), 16'hBEEF);
    for (int i = 0; i < n; i++) fb[i] = 8'($urandom);
    w0 = wr_cnt; i0 = irq_cnt; m0 = miss_cnt; t0 = cyc;
    send(n, ce, fe);
    repeat (10) @(negedge clk);
    check("R2 first access is flags word of slot", int'(start_addr), int'(d + 16'd1));
    if (!own) begin
      check("R3 missed pulse count", miss_cnt - m0, 1);
      check("R3 no memory write", wr_cnt - w0, 0);
      check("R3 flags word untouched", int'(mem[d[11:0]+12'd1]), 0);
      check("R3 count word untouched", int'(mem[d[11:0]+12'd3]), 16'hDEAD);
    end else begin
      bad = 0;
      for (int k = 0; k < nw; k++)
        if (mem[bufa[11:0] + 12'(k)] != exp_word(k, stored)) bad++;
      check("R4 buffer words mismatched", bad, 0);
      check("R6 word past stored data intact", int'(mem[bufa[11:0] + 12'(nw)]), 16'hBEEF);
      check("R5 byte count", int'(mem[d[11:0]+12'd3]), stored);
      check("R7 final status word", int'(mem[d[11:0]+12'd1]),
            int'({1'b0, 12'b0, ovf, fe, ce}));
      check("R6 overflow bit", int'(mem[d[11:0]+12'd1] >> 2) & 1, int'(ovf));
      check("R8 count before status", int'(len_t > t0 && stat_t > len_t), 1);
      check("R8 release last", int'(rel_t > stat_t && stat_seen[15]), 1);
      check("R9 irq count", irq_cnt - i0, int'(ien));
      if (ien) check("R9 irq cycle after release", irq_t, rel_t + 1);
      check("R3 no missed on owned slot", miss_cnt - m0, 0);
      exp_slot = (exp_slot + 1) & mask;
      if (prev == mask && mask != 0)
        check("R10 wrap to slot 0", exp_slot, 0);
    end
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
    mem_rdata = '0;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 in_ready low in reset", int'(in_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle outputs low", int'({in_ready, irq, missed, mem_rd, mem_wr}), 0);
    frame(10, 64, 1'b1, 1'b0, 1'b0, 1'b1);
    frame(7, 64, 1'b1, 1'b0, 1'b0, 1'b1);
    frame(20, 9, 1'b1, 1'b0, 1'b0, 1'b1);
    frame(12, 12, 1'b1, 1'b1, 1'b0, 1'b0);
    frame(5, 32, 1'b0, 1'b0, 1'b0, 1'b1);
    frame(6, 32, 1'b1, 1'b0, 1'b1, 1'b1);
    frame(3, 0, 1'b1, 1'b1, 1'b1, 1'b1);
    for (int r = 0; r < 16; r++)
      frame(1 + int'($urandom % 70), int'($urandom % 65), ($urandom % 5) != 0,
            1'($urandom), 1'($urandom), 1'($urandom));
    cfg_ring_log2 = 3'd0;
    for (int r = 0; r < 3; r++)
      frame(1 + int'($urandom % 30), 40, 1'b1, 1'b0, 1'b0, 1'b1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule